// File: doc/BRIEF.md
# Skewed-Bank Row/Column Matrix Store

This block stores an 8x8 matrix of words and lets a client read or write a whole row or a whole column as one 8-word vector in a single clock. The 64 words are spread over eight single-port banks, each eight words deep. Word (i,j) sits in bank i^j at word address i. Because of this skew, every row and every column touches each bank exactly once, so no access conflicts with itself.

An XOR-steered crossbar sits between the banks and the eight lanes and keeps the lanes in order. Lane k of a row-i access is always word (i,k), and lane k of a column-j access is always word (k,j). The same crossbar steering serves both the read path and the write path.

A typical use is a separable 2D transform. The client makes eight row passes and then eight column passes over the same stored data. It needs no transposition step and no second copy of the matrix.

Top module: `rc_matrix_store`

## Requirements
- R1: An active-low synchronous reset clears `rd_valid` and leaves every stored word unchanged. A vector written before reset reads back unchanged after reset.
- R2: A row read (`cmd_valid`=1, `cmd_write`=0, `cmd_col`=0, `cmd_idx`=i) returns word (i,k) on lane k. Lane k occupies bits [k*DW +: DW] of `rd_data`. The result is registered and appears one clock after the command.
- R3: A column read (`cmd_col`=1, `cmd_idx`=j) returns word (k,j) on lane k, one clock after the command.
- R4: A row write (`cmd_write`=1, `cmd_col`=0) stores lane k of `wr_data` into word (i,k) on the edge where the command is issued. A read issued on the following clock returns the new data.
- R5: A column write (`cmd_col`=1) stores lane k of `wr_data` into word (k,j) on the edge where the command is issued.
- R6: Rows and columns share one storage array. Data written as rows and read as columns appears transposed, and the reverse also holds.
- R7: `rd_valid` is 1 in the cycle after a read command and 0 after any other cycle. `rd_data` keeps its value when no read is issued.
- R8: A write changes only the eight words of the selected row or column.
- R9: With `cmd_valid`=0, no stored word changes, whatever `cmd_write` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears `rd_valid` only |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_write | input | 1 | 1 = vector write, 0 = vector read |
| cmd_col | input | 1 | 1 = column access, 0 = row access |
| cmd_idx | input | 3 | Row or column index |
| wr_data | input | 8*DW | Write vector, lane k at bits [k*DW +: DW] |
| rd_data | output | 8*DW | Read vector, registered, lane k at bits [k*DW +: DW] |
| rd_valid | output | 1 | `rd_data` was loaded by the previous cycle's read |

## Verification
A read's vector and its `rd_valid` are due on the first rising edge after the command. The bench drives each command on a falling edge and samples one falling edge after the next rising edge, so every read result is checked exactly one register stage after it was requested. A write takes effect on its issuing edge, so a read may be issued on the very next falling edge and is checked one clock after that. A bench-side 8x8 model, updated after each write, supplies all expected vectors. Full row and column sweeps cover every index under both orientations.

// File: rtl/rc_matrix_store.sv
module rc_matrix_store #(
  parameter int DW = 16,
  parameter int N  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            cmd_write,
  input  logic            cmd_col,
  input  logic [AW-1:0]   cmd_idx,
  input  logic [N*DW-1:0] wr_data,
  output logic [N*DW-1:0] rd_data,
  output logic            rd_valid
);

  logic          wr_en, rd_en;
  logic [DW-1:0] bank_q [N];
  logic [DW-1:0] lane_q [N];

  assign wr_en = cmd_valid &  cmd_write;
  assign rd_en = cmd_valid & ~cmd_write;

  for (genvar b = 0; b < N; b++) begin : g_bank
    localparam logic [AW-1:0] BID = AW'(b);
    logic [DW-1:0] mem [N];
    logic [AW-1:0] addr, src_lane;
    assign addr     = cmd_col ? (BID ^ cmd_idx) : cmd_idx;
    assign src_lane = BID ^ cmd_idx;
    always_ff @(posedge clk)
      if (wr_en) mem[addr] <= wr_data[src_lane*DW +: DW];
    assign bank_q[b] = mem[addr];
  end

  for (genvar k = 0; k < N; k++) begin : g_lane
    localparam logic [AW-1:0] LID = AW'(k);
    always_ff @(posedge clk)
      if (rd_en) lane_q[k] <= bank_q[LID ^ cmd_idx];
    assign rd_data[k*DW +: DW] = lane_q[k];
  end

  always_ff @(posedge clk)
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;

  assert_valid_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_no_valid_without_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_hold_without_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  assert_reset_clears_valid_R1: assert property (@(posedge clk)
    !rst_n |=> !rd_valid);
  assert_write_then_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en ##1 (rd_en && cmd_col == $past(cmd_col) && cmd_idx == $past(cmd_idx)))
    |=> rd_data == $past(wr_data, 2));

endmodule

// File: tb/rc_matrix_store_tb.sv
`timescale 1ns/1ps
module rc_matrix_store_tb;
  localparam int DW = 16;
  localparam int N  = 8;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0, cmd_col = 0;
  logic [2:0] cmd_idx = 0;
  logic [N*DW-1:0] wr_data = '0;
  logic [N*DW-1:0] rd_data;
  logic rd_valid;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [N][N];

  always #2 clk = ~clk;

  rc_matrix_store #(.DW(DW), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .cmd_idx(cmd_idx), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid));

  function automatic logic [DW-1:0] pat(int p, int i, int j);
    return DW'(p * 1237 + i * 73 + j * 5 + 1);
  endfunction

  function automatic logic [N*DW-1:0] expect_vec(logic col, int idx);
    logic [N*DW-1:0] v;
    for (int k = 0; k < N; k++)
      v[k*DW +: DW] = col ? model[k][idx] : model[idx][k];
    return v;
  endfunction

  task automatic check(string req, logic [N*DW-1:0] act, logic [N*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic col, int idx, int p);
    logic [N*DW-1:0] v;
    for (int k = 0; k < N; k++)
      v[k*DW +: DW] = col ? pat(p, k, idx) : pat(p, idx, k);
    cmd_valid = 1; cmd_write = 1; cmd_col = col; cmd_idx = 3'(idx); wr_data = v;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < N; k++)
      if (col) model[k][idx] = v[k*DW +: DW]; else model[idx][k] = v[k*DW +: DW];
    cmd_valid = 0; cmd_write = 0;
  endtask

  task automatic do_read(logic col, int idx, string req);
    cmd_valid = 1; cmd_write = 0; cmd_col = col; cmd_idx = 3'(idx);
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
    check({req, " data"}, rd_data, expect_vec(col, idx));
    check("R7 valid", {{(N*DW-1){1'b0}}, rd_valid}, {{(N*DW-1){1'b0}}, 1'b1});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N*DW-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {{(N*DW-1){1'b0}}, rd_valid}, '0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < N; i++) do_write(0, i, 1);
    for (int i = 0; i < N; i++) do_read(0, i, "R2 row read");
    for (int j = 0; j < N; j++) do_read(1, j, "R6 transposed col read");

    for (int j = 0; j < N; j++) do_write(1, j, 2);
    for (int j = 0; j < N; j++) do_read(1, j, "R3 col read");
    for (int i = 0; i < N; i++) do_read(0, i, "R6 transposed row read");

    for (int i = 0; i < N; i++) begin
      do_write(0, i, 10 + i);
      do_read(0, i, "R4 row write then read");
    end
    for (int j = 0; j < N; j++) begin
      do_write(1, j, 20 + j);
      do_read(1, j, "R5 col write then read");
      for (int i = 0; i < N; i++) do_read(0, i, "R8 other words kept");
    end

    do_read(0, 3, "R7 prep");
    held = rd_data;
    @(negedge clk);
    check("R7 valid low when idle", {{(N*DW-1){1'b0}}, rd_valid}, '0);
    check("R7 data held", rd_data, held);
    do_write(0, 5, 30);
    check("R7 data held after write", rd_data, held);
    check("R7 valid low after write", {{(N*DW-1){1'b0}}, rd_valid}, '0);

    cmd_valid = 0; cmd_write = 1; cmd_col = 1; cmd_idx = 3'd2; wr_data = '1;
    repeat (2) @(negedge clk);
    cmd_write = 0;
    for (int i = 0; i < N; i++) do_read(0, i, "R9 idle no write");

    do_write(1, 6, 40);
    do_read(0, 1, "R1 prep");
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 valid cleared", {{(N*DW-1){1'b0}}, rd_valid}, '0);
    rst_n = 1;
    @(negedge clk);
    for (int j = 0; j < N; j++) do_read(1, j, "R1 contents kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule